// File: doc/BRIEF.md
# Universal Bidirectional Shift Register

This block is a parameterised shift register that can perform one of four operations: parallel load, hold, shift toward the MSB end, or shift toward bit 0. Shifting toward bit 0 takes its fill bit from its own serial input. Shifting toward the MSB takes its fill bit from a second, separate serial input. A 2-bit mode field picks the operation. An enable input can suppress any operation.

The register's own clock is the `tick` input. Everything in the block is clocked by the chip clock `clk`, and `tick` is sampled on that clock. A compile-time parameter picks how `tick` is read:

- **Edge variant:** exactly one operation happens per rising edge of `tick`.
- **Level variant:** the register is transparent. The selected operation repeats on every `clk` cycle while `tick` stays high, so a long high phase gives several shifts.

A small phase state machine tracks `tick` and has two states:

- `PH_LOW`: `tick` was low on the last sample.
- `PH_HIGH`: `tick` was high on the last sample.

Its transitions are:

- "rise": `PH_LOW` to `PH_HIGH` when `tick` is high.
- "fall": `PH_HIGH` to `PH_LOW` when `tick` is low.
- "stay": the state is kept otherwise.

The state machine raises an internal fire pulse under these conditions:

- On the rise, in both variants.
- In `PH_HIGH` while `tick` is high, in the level variant only.

The register is built from 4-bit slices. Setting `NUM_SLICES` to 2 gives an 8-bit register. In that case the serial data passes between neighbouring slices, so the result acts as one wide register. A synchronous active-low reset clears the contents and the phase state.

Top module: `shreg_universal`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `q` becomes all zeros at that edge.
- R2: Mode 2'b01 (load) on an applied operation sets `q` to `d`.
- R3: Mode 2'b00 (hold) leaves `q` unchanged.
- R4: Mode 2'b10 (shift right) on an applied operation sets `q` to `{ser_r, q[WIDTH-1:1]}`. This means `ser_r` enters the MSB.
- R5: Mode 2'b11 (shift left) on an applied operation sets `q` to `{q[WIDTH-2:0], ser_l}`. This means `ser_l` enters bit 0.
- R6: With `en` low, `q` keeps its value whatever `mode`, `d`, the serial inputs and `tick` do.
- R7: In the edge variant (`LEVEL_MODE`=0), exactly one operation occurs per rising edge of `tick`, however long `tick` then stays high.
- R8: In the level variant (`LEVEL_MODE`=1), the operation repeats on every `clk` edge at which `tick` is sampled high.
- R9: While `tick` is sampled low, `q` does not change in either variant.
- R10: With two slices, the bit leaving one slice enters the other in both shift directions. The 8-bit register then matches a single 8-bit register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low clear |
| tick | input | 1 | Register clock, read as edge or level per `LEVEL_MODE` |
| en | input | 1 | Operation enable |
| mode | input | 2 | 00 hold, 01 load, 10 shift right, 11 shift left |
| ser_r | input | 1 | Fill bit entering the MSB on a right shift |
| ser_l | input | 1 | Fill bit entering bit 0 on a left shift |
| d | input | WIDTH | Parallel load word |
| q | output | WIDTH | Register contents |

## Verification
The hardest case to reach is the one that separates the two variants: `tick` held high for several chip-clock cycles, with the same inputs feeding an edge instance and a level instance side by side. The bench first loads a single set bit into both instances. It then holds `tick` high for three sampled edges in left-shift mode. The level instance should have moved the bit three places and the edge instance one place. A second hard case is the transfer between slices in the 8-bit build. For this, a pattern is loaded with the set bit at the seam between slices, and it is shifted in both directions.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_LOAD = 2'b01,
        OP_SHR  = 2'b10,
        OP_SHL  = 2'b11
    } shreg_op_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } tick_phase_e;

endpackage

// File: rtl/shreg_phase_fsm.sv
module shreg_phase_fsm
    import shreg_pkg::*;
#(
    parameter bit LEVEL_MODE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic fire
);

    tick_phase_e phase_q;
    tick_phase_e phase_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_LOW;
        end else begin
            phase_q <= phase_d;
        end
    end

    // transitions: rise, fall, stay
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_LOW:  if (tick)  phase_d = PH_HIGH;
            PH_HIGH: if (!tick) phase_d = PH_LOW;
            default: phase_d = PH_LOW;
        endcase
    end

    // outputs
    always_comb begin
        fire = 1'b0;
        unique case (phase_q)
            PH_LOW:  fire = tick;
            PH_HIGH: fire = tick && LEVEL_MODE;
            default: fire = 1'b0;
        endcase
    end

    generate
        if (!LEVEL_MODE) begin : g_edge_chk
            AST_EDGE_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
                fire |=> !fire); // R7
        end
    endgenerate

endmodule

// File: rtl/shreg_op_calc.sv
module shreg_op_calc
    import shreg_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  shreg_op_e          op,
    input  logic [SLICE_W-1:0] cur,
    input  logic [SLICE_W-1:0] load_val,
    input  logic               fill_msb,
    input  logic               fill_lsb,
    output logic [SLICE_W-1:0] nxt
);

    always_comb begin
        nxt = cur;
        unique case (op)
            OP_HOLD: nxt = cur;
            OP_LOAD: nxt = load_val;
            OP_SHR:  nxt = {fill_msb, cur[SLICE_W-1:1]};
            OP_SHL:  nxt = {cur[SLICE_W-2:0], fill_lsb};
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/shreg_slice.sv
module shreg_slice
    import shreg_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               apply,
    input  shreg_op_e          op,
    input  logic               fill_msb,
    input  logic               fill_lsb,
    input  logic [SLICE_W-1:0] load_val,
    output logic [SLICE_W-1:0] q
);

    logic [SLICE_W-1:0] nxt;

    shreg_op_calc #(.SLICE_W(SLICE_W)) u_calc (
        .op       (op),
        .cur      (q),
        .load_val (load_val),
        .fill_msb (fill_msb),
        .fill_lsb (fill_lsb),
        .nxt      (nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (apply) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/shreg_universal.sv
module shreg_universal
    import shreg_pkg::*;
#(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 1,
    parameter bit LEVEL_MODE = 1'b0,
    localparam int WIDTH     = SLICE_W * NUM_SLICES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic             ser_r,
    input  logic             ser_l,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    shreg_op_e        op;
    logic             fire;
    logic             apply;
    logic [WIDTH-1:0] q_int;

    assign op    = shreg_op_e'(mode);
    assign apply = fire && en;
    assign q     = q_int;

    shreg_phase_fsm #(.LEVEL_MODE(LEVEL_MODE)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .fire  (fire)
    );

    generate
        for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
            logic msb_in;
            logic lsb_in;
            if (s == NUM_SLICES - 1) begin : g_top
                assign msb_in = ser_r;
            end else begin : g_mid_r
                assign msb_in = q_int[(s + 1) * SLICE_W];
            end
            if (s == 0) begin : g_bot
                assign lsb_in = ser_l;
            end else begin : g_mid_l
                assign lsb_in = q_int[s * SLICE_W - 1];
            end
            shreg_slice #(.SLICE_W(SLICE_W)) u_slice (
                .clk      (clk),
                .rst_n    (rst_n),
                .apply    (apply),
                .op       (op),
                .fill_msb (msb_in),
                .fill_lsb (lsb_in),
                .load_val (d[s * SLICE_W +: SLICE_W]),
                .q        (q_int[s * SLICE_W +: SLICE_W])
            );
        end
    endgenerate

    AST_SYNC_CLEAR: assert property (@(posedge clk)
        !rst_n |=> q == '0); // R1
    AST_LOAD_TAKES_D: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && en && op == OP_LOAD) |=> q == $past(d)); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(q)); // R3
    AST_SHR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && en && op == OP_SHR) |=> q == {$past(ser_r), $past(q[WIDTH-1:1])}); // R4
    AST_SHL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && en && op == OP_SHL) |=> q == {$past(q[WIDTH-2:0]), $past(ser_l)}); // R5
    AST_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q)); // R6
    AST_TICK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(q)); // R9

    generate
        if (LEVEL_MODE) begin : g_level_chk
            AST_LEVEL_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
                (tick && en && op == OP_SHL) |=> q == {$past(q[WIDTH-2:0]), $past(ser_l)}); // R8
        end
    endgenerate

endmodule

// File: tb/shreg_universal_bench.sv
module shreg_universal_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       ser_r = 1'b0;
    logic       ser_l = 1'b0;
    logic [3:0] d4 = '0;
    logic [7:0] d8 = '0;
    logic [3:0] q_e;
    logic [3:0] q_l;
    logic [7:0] q_w;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shreg_universal #(.SLICE_W(4), .NUM_SLICES(1), .LEVEL_MODE(1'b0)) u_shreg_universal (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .mode(mode),
        .ser_r(ser_r), .ser_l(ser_l), .d(d4), .q(q_e));

    shreg_universal #(.SLICE_W(4), .NUM_SLICES(1), .LEVEL_MODE(1'b1)) u_shreg_universal_lvl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .mode(mode),
        .ser_r(ser_r), .ser_l(ser_l), .d(d4), .q(q_l));

    shreg_universal #(.SLICE_W(4), .NUM_SLICES(2), .LEVEL_MODE(1'b0)) u_shreg_universal_wide (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .mode(mode),
        .ser_r(ser_r), .ser_l(ser_l), .d(d8), .q(q_w));

    // {en, mode, ser_r, ser_l, d, expected q}
    localparam logic [12:0] VEC [12] = '{
        13'b1_01_0_0_1011_1011,
        13'b1_00_0_0_0000_1011,
        13'b1_10_1_0_0000_1101,
        13'b1_10_0_0_0000_0110,
        13'b1_11_0_1_0000_1101,
        13'b1_11_0_0_0000_1010,
        13'b0_01_0_0_0101_1010,
        13'b0_11_0_1_0000_1010,
        13'b1_01_0_0_0110_0110,
        13'b1_11_0_1_0000_1101,
        13'b1_10_1_0_0000_1110,
        13'b1_01_0_0_0000_0000
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // one-cycle tick pulse; returns at the negedge after the update
    task automatic pulse(input logic e, input logic [1:0] m, input logic r, input logic l,
                         input logic [3:0] v4, input logic [7:0] v8);
        en = e; mode = m; ser_r = r; ser_l = l; d4 = v4; d8 = v8;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic e, input logic [1:0] m);
        if (!e) return "R6 enable low";
        case (m)
            2'b00:   return "R3 hold";
            2'b01:   return "R2 load";
            2'b10:   return "R4 shift right";
            default: return "R5 shift left";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset edge", {4'h0, q_e}, 8'h00);
        check("R1 reset level", {4'h0, q_l}, 8'h00);
        check("R1 reset wide", q_w, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 12; i++) begin
            logic [12:0] v;
            v = VEC[i];
            pulse(v[12], v[11:10], v[9], v[8], v[7:4], 8'h00);
            check({tag_of(v[12], v[11:10]), " edge"}, {4'h0, q_e}, {4'h0, v[3:0]});
            check({tag_of(v[12], v[11:10]), " level"}, {4'h0, q_l}, {4'h0, v[3:0]});
        end

        // R9: tick low, load requested, nothing happens
        pulse(1'b1, 2'b01, 1'b0, 1'b0, 4'b0101, 8'h00);
        en = 1'b1; mode = 2'b01; d4 = 4'b1111; tick = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 tick low edge", {4'h0, q_e}, 8'h05);
        check("R9 tick low level", {4'h0, q_l}, 8'h05);

        // R7 / R8: tick held high for three sampled edges
        pulse(1'b1, 2'b01, 1'b0, 1'b0, 4'b0001, 8'h00);
        en = 1'b1; mode = 2'b11; ser_l = 1'b0; tick = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 single op per rise", {4'h0, q_e}, 8'h02);
        check("R8 repeated op while high", {4'h0, q_l}, 8'h08);
        tick = 1'b0;
        @(negedge clk);
        check("R7 stable after fall", {4'h0, q_e}, 8'h02);
        check("R8 stops after fall", {4'h0, q_l}, 8'h08);

        // R10: chained 8-bit register
        pulse(1'b1, 2'b01, 1'b0, 1'b0, 4'h0, 8'b0000_1001);
        check("R10 wide load", q_w, 8'b0000_1001);
        pulse(1'b1, 2'b11, 1'b0, 1'b0, 4'h0, 8'h00);
        check("R10 wide left cross", q_w, 8'b0001_0010);
        pulse(1'b1, 2'b10, 1'b1, 1'b0, 4'h0, 8'h00);
        check("R10 wide right cross", q_w, 8'b1000_1001);
        pulse(1'b1, 2'b11, 1'b0, 1'b1, 4'h0, 8'h00);
        check("R10 wide left fill", q_w, 8'b0001_0011);

        // R1: synchronous clear of loaded contents
        pulse(1'b1, 2'b01, 1'b0, 1'b0, 4'b1111, 8'hFF);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 clear edge", {4'h0, q_e}, 8'h00);
        check("R1 clear level", {4'h0, q_l}, 8'h00);
        check("R1 clear wide", q_w, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule